// File: doc/BRIEF.md
# Instruction Stream Cache Compressor

This block shrinks a trace of retired instruction addresses as it is produced. A program-counter value arrives with a valid strobe, at most one per cycle. The block cuts the sequence into instruction streams. A stream is a run of instructions that each sit four bytes after the one before. A stream ends at the first instruction whose successor breaks that rule. Each stream is reduced to the pair (start address, instruction count).

Each pair waits in a small queue and is then looked up in a set-associative stream cache. A hit puts a short nonzero index on the index trace. A miss puts the reserved index zero on the index trace, puts the full pair on the miss trace, and installs the pair in the cache. A downstream stage can rebuild the whole address trace from these two outputs.

Top module: `stream_cache_compressor`

## Requirements
- R1: After reset, idx_valid and miss_valid are low. Neither rises until a stream has been closed.
- R2: With pc_valid high, a pc that differs from the previous accepted pc by anything other than +4 closes the open stream. The closed pair is (first pc of the stream, number of pcs in it), and the new pc starts the next stream.
- R3: A stream that has reached 2^LEN_W-1 instructions closes even when the next pc is sequential. That pc then starts a new stream.
- R4: flush with pc_valid low closes the open stream as a normal pair. flush with no open stream produces nothing. flush while pc_valid is high has no effect.
- R5: The set of a pair is ((start >> 2) XOR length) mod SETS.
- R6: A hit emits idx = set*WAYS + way + 1 with miss_valid low. The output is registered at the edge after the lookup cycle.
- R7: A miss emits idx = 0 together with miss_valid and the pair on miss_sa and miss_len, two edges after the lookup starts. The pair is installed, so the next identical pair hits.
- R8: An install uses the lowest-numbered invalid way of the set, or else the least recently used way. Installs and hits both make the entry the most recently used.
- R9: There is exactly one idx_valid pulse per closed stream, in the order the streams closed.
- R10: The pair queue never overflows while every stream is at least two instructions long.
- R11: idx never exceeds SETS*WAYS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_valid | input | 1 | A retired pc is present |
| pc | input | ADDR_W | Retired instruction address |
| flush | input | 1 | Close the open stream (honoured only when pc_valid is low) |
| idx_valid | output | 1 | One index-trace entry this cycle |
| idx | output | IDX_W | Stream cache index; 0 means miss |
| miss_valid | output | 1 | Miss-trace entry this cycle |
| miss_sa | output | ADDR_W | Start address of the missed stream |
| miss_len | output | LEN_W | Length of the missed stream |

## Verification
The bench builds the block with 4 sets, 2 ways, a 4-bit length field and a 4-entry queue. With the small cache, a handful of distinct streams is enough to collide in one set and force LRU evictions. With the short length field, a 20-instruction run is enough to reach length saturation. Directed cases cover the exact hit and miss latencies, the hash result for a known pair, and all three flush conditions. Random streams drawn from a small pool with a fixed seed then mix hits, misses and evictions, and the index and miss traces are compared in order against a reference cache model in the bench.

// File: rtl/scc_pkg.sv
package scc_pkg;

  // Set selection: word address XOR stream length, reduced to the set count.
  function automatic logic [31:0] hash_set(input logic [63:0] sa,
                                           input logic [31:0] len,
                                           input int unsigned sets);
    logic [63:0] mix;
    mix = (sa >> 2) ^ {32'd0, len};
    return 32'(mix % 64'(sets));
  endfunction

  // Index encoding; value zero stays reserved for a miss.
  function automatic logic [31:0] encode_index(input logic [31:0] set,
                                               input logic [31:0] way,
                                               input int unsigned ways);
    return set * ways + way + 32'd1;
  endfunction

endpackage

// File: rtl/scc_stream_detect.sv
module scc_stream_detect #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pc_valid,
  input  logic [ADDR_W-1:0] pc,
  input  logic              flush,
  output logic              push,
  output logic [ADDR_W-1:0] push_sa,
  output logic [LEN_W-1:0]  push_len
);
  localparam logic [LEN_W-1:0] LEN_MAX = '1;

  logic              active;
  logic [ADDR_W-1:0] start_q, prev_q;
  logic [LEN_W-1:0]  len_q;
  logic              seq, sat, brk, fl_close;

  assign seq      = (pc == prev_q + ADDR_W'(4));
  assign sat      = (len_q == LEN_MAX);
  assign brk      = pc_valid && active && (!seq || sat);
  assign fl_close = !pc_valid && flush && active;
  assign push     = brk || fl_close;
  assign push_sa  = start_q;
  assign push_len = len_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      start_q <= '0;
      prev_q  <= '0;
      len_q   <= '0;
    end else if (pc_valid) begin
      prev_q <= pc;
      if (!active || brk) begin
        active  <= 1'b1;
        start_q <= pc;
        len_q   <= LEN_W'(1);
      end else begin
        len_q <= len_q + LEN_W'(1);
      end
    end else if (fl_close) begin
      active <= 1'b0;
    end
  end
endmodule

// File: rtl/scc_pair_fifo.sv
module scc_pair_fifo #(
  parameter int W     = 40,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) begin
        mem[wr_ptr] <= din;
        wr_ptr      <= bump(wr_ptr);
      end
      if (do_pop) rd_ptr <= bump(rd_ptr);
      if (do_push && !do_pop)      count <= count + CNT_W'(1);
      else if (do_pop && !do_push) count <= count - CNT_W'(1);
    end
  end
endmodule

// File: rtl/scc_stream_cache.sv
module scc_stream_cache
  import scc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int SETS   = 32,
  parameter int WAYS   = 4,
  parameter int IDX_W  = $clog2(SETS * WAYS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              head_valid,
  input  logic [ADDR_W-1:0] head_sa,
  input  logic [LEN_W-1:0]  head_len,
  output logic              pop,
  output logic              idx_valid,
  output logic [IDX_W-1:0]  idx,
  output logic              miss_valid,
  output logic [ADDR_W-1:0] miss_sa,
  output logic [LEN_W-1:0]  miss_len,
  output logic              eng_hit,
  output logic              eng_lookup_miss,
  output logic              eng_install
);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);

  logic              valid   [SETS][WAYS];
  logic [ADDR_W-1:0] tag_sa  [SETS][WAYS];
  logic [LEN_W-1:0]  tag_len [SETS][WAYS];
  logic [WAY_W-1:0]  age     [SETS][WAYS];

  logic             busy;
  logic [SET_W-1:0] set_q, cur_set, touch_set;
  logic [WAY_W-1:0] victim_q, hit_way, victim, touch_way;
  logic             hit_any, have_free, touch_en;

  assign cur_set = SET_W'(hash_set(64'(head_sa), 32'(head_len), SETS));

  always_comb begin
    hit_any   = 1'b0;
    hit_way   = '0;
    have_free = 1'b0;
    victim    = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (valid[cur_set][w] && tag_sa[cur_set][w] == head_sa &&
          tag_len[cur_set][w] == head_len) begin
        hit_any = 1'b1;
        hit_way = WAY_W'(w);
      end
      if (!valid[cur_set][w]) begin
        have_free = 1'b1;
        victim    = WAY_W'(w);
      end
    end
    if (!have_free) begin
      for (int w = 0; w < WAYS; w++)
        if (age[cur_set][w] == WAY_W'(WAYS - 1)) victim = WAY_W'(w);
    end
  end

  assign eng_hit         = head_valid && !busy && hit_any;
  assign eng_lookup_miss = head_valid && !busy && !hit_any;
  assign eng_install     = busy;
  assign pop             = eng_hit || eng_install;
  assign touch_en        = eng_hit || eng_install;
  assign touch_set       = eng_install ? set_q : cur_set;
  assign touch_way       = eng_install ? victim_q : hit_way;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      set_q      <= '0;
      victim_q   <= '0;
      idx_valid  <= 1'b0;
      idx        <= '0;
      miss_valid <= 1'b0;
      miss_sa    <= '0;
      miss_len   <= '0;
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          valid[s][w] <= 1'b0;
          age[s][w]   <= WAY_W'(w);
        end
    end else begin
      idx_valid  <= 1'b0;
      miss_valid <= 1'b0;
      if (eng_hit) begin
        idx_valid <= 1'b1;
        idx       <= IDX_W'(encode_index(32'(cur_set), 32'(hit_way), WAYS));
      end
      if (eng_lookup_miss) begin
        busy     <= 1'b1;
        set_q    <= cur_set;
        victim_q <= victim;
      end
      if (eng_install) begin
        busy                     <= 1'b0;
        valid[set_q][victim_q]   <= 1'b1;
        tag_sa[set_q][victim_q]  <= head_sa;
        tag_len[set_q][victim_q] <= head_len;
        idx_valid                <= 1'b1;
        idx                      <= '0;
        miss_valid               <= 1'b1;
        miss_sa                  <= head_sa;
        miss_len                 <= head_len;
      end
      if (touch_en) begin
        for (int j = 0; j < WAYS; j++) begin
          if (WAY_W'(j) == touch_way)
            age[touch_set][j] <= '0;
          else if (age[touch_set][j] < age[touch_set][touch_way])
            age[touch_set][j] <= age[touch_set][j] + WAY_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/stream_cache_compressor.sv
module stream_cache_compressor #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 8,
  parameter int SETS       = 32,
  parameter int WAYS       = 4,
  parameter int FIFO_DEPTH = 4,
  parameter int IDX_W      = $clog2(SETS * WAYS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pc_valid,
  input  logic [ADDR_W-1:0] pc,
  input  logic              flush,
  output logic              idx_valid,
  output logic [IDX_W-1:0]  idx,
  output logic              miss_valid,
  output logic [ADDR_W-1:0] miss_sa,
  output logic [LEN_W-1:0]  miss_len
);
  localparam int PAIR_W = ADDR_W + LEN_W;

  logic              fifo_push, fifo_pop, fifo_empty, fifo_full;
  logic [ADDR_W-1:0] det_sa;
  logic [LEN_W-1:0]  det_len;
  logic [PAIR_W-1:0] head;
  logic              eng_hit, eng_lookup_miss, eng_install;

  scc_stream_detect #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) detect_i (
    .clk(clk), .rst_n(rst_n), .pc_valid(pc_valid), .pc(pc), .flush(flush),
    .push(fifo_push), .push_sa(det_sa), .push_len(det_len)
  );

  scc_pair_fifo #(.W(PAIR_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n), .push(fifo_push), .din({det_sa, det_len}),
    .pop(fifo_pop), .dout(head), .empty(fifo_empty), .full(fifo_full)
  );

  scc_stream_cache #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SETS(SETS),
                     .WAYS(WAYS), .IDX_W(IDX_W)) cache_i (
    .clk(clk), .rst_n(rst_n), .head_valid(!fifo_empty),
    .head_sa(head[PAIR_W-1:LEN_W]), .head_len(head[LEN_W-1:0]),
    .pop(fifo_pop), .idx_valid(idx_valid), .idx(idx),
    .miss_valid(miss_valid), .miss_sa(miss_sa), .miss_len(miss_len),
    .eng_hit(eng_hit), .eng_lookup_miss(eng_lookup_miss),
    .eng_install(eng_install)
  );
endmodule

// File: rtl/scc_checks.sv
module scc_checks #(
  parameter int SETS  = 32,
  parameter int WAYS  = 4,
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             idx_valid,
  input logic [IDX_W-1:0] idx,
  input logic             miss_valid,
  input logic             eng_hit,
  input logic             eng_lookup_miss,
  input logic             eng_install,
  input logic             fifo_push,
  input logic             fifo_full
);
  assert_hit_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    eng_hit |=> (idx_valid && idx != '0 && !miss_valid));

  assert_miss_second_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_lookup_miss |=> (eng_install && !idx_valid));

  assert_miss_output_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_install |=> (idx_valid && idx == '0 && miss_valid));

  assert_miss_zero_idx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |-> (idx_valid && idx == '0));

  assert_idx_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    idx_valid |-> (int'(idx) <= SETS * WAYS));

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> !fifo_full);
endmodule

bind stream_cache_compressor scc_checks #(.SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .idx_valid(idx_valid), .idx(idx),
  .miss_valid(miss_valid), .eng_hit(eng_hit), .eng_lookup_miss(eng_lookup_miss),
  .eng_install(eng_install), .fifo_push(fifo_push), .fifo_full(fifo_full)
);

// File: tb/stream_cache_compressor_tb_top.sv
`timescale 1ns/1ps
module stream_cache_compressor_tb_top;
  localparam int AW = 32, LW = 4, NS = 4, NW = 2, FD = 4;
  localparam int IW = $clog2(NS * NW + 1);
  localparam int LMAX = (1 << LW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, pc_valid = 1'b0, flush = 1'b0;
  logic [AW-1:0] pc = '0;
  logic idx_valid, miss_valid;
  logic [IW-1:0] idx;
  logic [AW-1:0] miss_sa;
  logic [LW-1:0] miss_len;

  always #2.5 clk = ~clk;

  stream_cache_compressor #(.ADDR_W(AW), .LEN_W(LW), .SETS(NS), .WAYS(NW),
                            .FIFO_DEPTH(FD)) dut_i (
    .clk(clk), .rst_n(rst_n), .pc_valid(pc_valid), .pc(pc), .flush(flush),
    .idx_valid(idx_valid), .idx(idx), .miss_valid(miss_valid),
    .miss_sa(miss_sa), .miss_len(miss_len));

  int checks = 0, errors = 0, cyc = 0, outs = 0, last_out_cyc = 0, last_idx = 0;
  bit done = 0;
  string cur_tag = "R1";

  // reference cache model
  bit m_valid [NS][NW];
  logic [AW-1:0] m_sa [NS][NW];
  int m_len [NS][NW];
  int m_stamp [NS][NW];
  int stamp = 0;
  // reference stream model
  bit b_active = 0;
  logic [AW-1:0] b_start, b_prev;
  int b_len;
  // expected outputs
  int e_idx[$]; bit e_miss[$]; logic [AW-1:0] e_sa[$]; int e_len[$]; string e_tag[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int b_set(input logic [AW-1:0] sa, input int len);
    return int'((sa / 4) % NS) ^ (len % NS);
  endfunction

  task automatic model_close(input logic [AW-1:0] sa, input int len);
    int s, w, v;
    s = b_set(sa, len);
    w = -1;
    for (int k = 0; k < NW; k++)
      if (m_valid[s][k] && m_sa[s][k] == sa && m_len[s][k] == len) w = k;
    stamp++;
    if (w >= 0) begin
      m_stamp[s][w] = stamp;
      e_idx.push_back(s * NW + w + 1); e_miss.push_back(0);
    end else begin
      v = -1;
      for (int k = NW - 1; k >= 0; k--) if (!m_valid[s][k]) v = k;
      if (v < 0) begin
        v = 0;
        for (int k = 1; k < NW; k++) if (m_stamp[s][k] < m_stamp[s][v]) v = k;
      end
      m_valid[s][v] = 1; m_sa[s][v] = sa; m_len[s][v] = len; m_stamp[s][v] = stamp;
      e_idx.push_back(0); e_miss.push_back(1);
    end
    e_sa.push_back(sa); e_len.push_back(len); e_tag.push_back(cur_tag);
  endtask

  task automatic drive_pc(input logic [AW-1:0] a, input bit fl = 0);
    @(negedge clk);
    pc_valid = 1; pc = a; flush = fl;
    if (!b_active) begin
      b_active = 1; b_start = a; b_len = 1;
    end else if (a == b_prev + 4 && b_len < LMAX) begin
      b_len++;
    end else begin
      model_close(b_start, b_len);
      b_start = a; b_len = 1;
    end
    b_prev = a;
  endtask

  task automatic drive_idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); pc_valid = 0; flush = 0;
    end
  endtask

  task automatic do_flush();
    @(negedge clk); pc_valid = 0; flush = 1;
    if (b_active) begin model_close(b_start, b_len); b_active = 0; end
  endtask

  task automatic run_stream(input logic [AW-1:0] sa, input int len);
    for (int i = 0; i < len; i++) drive_pc(sa + AW'(4 * i));
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // output monitor, away from the active edge
  always @(negedge clk) if (rst_n && idx_valid) begin
    outs++; last_out_cyc = cyc; last_idx = int'(idx);
    if (e_idx.size() == 0) begin
      check(0, "R9 unexpected output", int'(idx), -1);
    end else begin
      string t; int ei; bit em; logic [AW-1:0] es; int el;
      t = e_tag.pop_front(); ei = e_idx.pop_front(); em = e_miss.pop_front();
      es = e_sa.pop_front(); el = e_len.pop_front();
      check(int'(idx) == ei, {t, " idx"}, int'(idx), ei);
      check(miss_valid == em, {t, " miss_valid"}, int'(miss_valid), int'(em));
      if (em) begin
        check(miss_sa == es, {t, " miss_sa"}, int'(miss_sa), int'(es));
        check(int'(miss_len) == el, {t, " miss_len"}, int'(miss_len), el);
      end
    end
  end

  always @(posedge clk) if (cyc > 150000 && !done) begin
    done = 1; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int close_cyc, n0;
    logic [AW-1:0] pool_sa [10];
    int pool_len [10];
    void'($urandom(32'd12345));
    for (int s = 0; s < NS; s++) for (int w = 0; w < NW; w++) m_valid[s][w] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!idx_valid && !miss_valid, "R1 outputs after reset", int'(idx_valid), 0);

    // R1/R2: an open stream yields nothing
    cur_tag = "R7";
    run_stream(32'h100, 3);
    drive_idle(5);
    check(outs == 0, "R1 no output before close", outs, 0);
    // R2 close by non-sequential pc; R7 miss latency
    drive_pc(32'h500); close_cyc = cyc + 1;
    drive_pc(32'h504);
    drive_idle(5);
    check(outs == 1, "R2 one output per close", outs, 1);
    check(last_out_cyc - close_cyc == 2, "R7 miss latency", last_out_cyc - close_cyc, 2);
    // R4 flush closes the open stream
    cur_tag = "R4";
    do_flush(); drive_idle(5);
    check(outs == 2, "R4 flush closes stream", outs, 2);
    // R6 hit latency and R5 index value: (0x100,3) -> set 3, way 0 -> idx 7
    cur_tag = "R6";
    run_stream(32'h100, 3);
    do_flush(); close_cyc = cyc + 1;
    drive_idle(5);
    check(last_out_cyc - close_cyc == 1, "R6 hit latency", last_out_cyc - close_cyc, 1);
    check(last_idx == 7, "R5 hashed index", last_idx, 7);
    // R4 flush with nothing open, and flush with pc_valid high
    n0 = outs;
    do_flush(); drive_idle(6);
    check(outs == n0, "R4 flush idle stream ignored", outs, n0);
    cur_tag = "R4";
    drive_pc(32'h700); drive_pc(32'h704, 1); drive_pc(32'h708);
    drive_idle(6);
    check(outs == n0, "R4 flush with pc_valid ignored", outs, n0);
    do_flush(); drive_idle(6);
    check(outs == n0 + 1, "R4 stream kept through ignored flush", outs, n0 + 1);
    // R3 saturation: 20 sequential -> (0x800,15) and (0x83C,5)
    cur_tag = "R3";
    run_stream(32'h800, 20);
    do_flush(); drive_idle(8);
    check(last_idx == 0 && outs == n0 + 3, "R3 saturation split", outs, n0 + 3);
    // R8 LRU: three pairs of length 4 that all land in set 0
    cur_tag = "R8";
    run_stream(32'h200, 4); run_stream(32'h300, 4); run_stream(32'h200, 4);
    run_stream(32'h400, 4); run_stream(32'h300, 4); run_stream(32'h200, 4);
    run_stream(32'h400, 4);
    do_flush(); drive_idle(10);
    // R9 random mix from a small pool
    cur_tag = "R9";
    for (int i = 0; i < 10; i++) begin
      pool_sa[i] = 32'h1000 + AW'(i * 256) + AW'(($urandom % 8) * 16);
      pool_len[i] = 2 + int'($urandom % 13);
    end
    for (int n = 0; n < 300; n++) begin
      int k;
      k = int'($urandom % 10);
      run_stream(pool_sa[k], pool_len[k]);
      if ($urandom % 3 == 0) drive_idle(1 + int'($urandom % 2));
    end
    do_flush(); drive_idle(20);
    check(e_idx.size() == 0, "R9 all streams reported", e_idx.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule